// File: doc/BRIEF.md
# Pointer-Operand Read-After-Write Stall Unit

This unit sits between operand fetch and writeback of a two-stage pipeline whose sixteen working registers also appear in the data address space. In each cycle it looks at the instruction now entering operand fetch (the consumer) and at the instruction it last let through, which is now writing back (the producer). A stall is raised only when the consumer builds its source address from a working register that the producer changes in that same cycle. The producer can change a register in three ways: by naming it as a direct destination, by modifying its own destination pointer before or after use, or by storing to data memory at the address where that register is mapped.

When a stall is raised, fetch and decode hold their contents for one cycle and a NOP goes into execute. The unit keeps its own copy of the producer's destination fields. On a stall it clears the valid bit of that copy, so the held consumer meets an empty slot on the next cycle and proceeds without stalling again. Register Wk is mapped at byte address MAP_BASE + 2*k. The effective write address of the producer arrives from writeback in the cycle the comparison is made.

Top module: `raw_hz_detect`

## Requirements
- R1: After reset is released, and in the first cycle after any reset, no stall is raised, because the producer slot is empty.
- R2: A consumer whose source mode is direct (code 2'b00) never causes a stall, whatever the producer wrote.
- R3: A producer with a direct destination Wn (code 2'b00), followed by a consumer that reads through Wn, stalls for one cycle. This applies to plain indirect (2'b01), post-modified (2'b10) and pre-modified (2'b11) sources.
- R4: A producer with a plain indirect destination (2'b01) whose effective write address lies outside the register window (for example 0x0020 or 0x0100, with MAP_BASE 0) causes no stall.
- R5: A producer whose indirect store lands at a byte address A inside the window 0x0000–0x001F stalls a consumer that reads through register A>>1. Both bytes of a register count, so 0x0005 maps to W2 and 0x001E maps to W15.
- R6: A producer with a post-modified or pre-modified destination pointer Wn causes no stall for a direct read of Wn. It causes one stall for any indirect read through Wn.
- R7: If the register the producer changes differs from the consumer's source pointer register, there is no stall.
- R8: A stall lasts exactly one cycle. When the same consumer is presented in the next cycle, no stall is raised. fetch_hold is high in exactly the cycles in which stall_req is high.
- R9: An invalid consumer never stalls. A consumer that follows an invalid instruction never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fet_valid | input | 1 | Instruction entering operand fetch is valid |
| fet_dst_mode | input | 2 | Destination addressing mode: 00 direct, 01 indirect, 10 post-modified, 11 pre-modified |
| fet_dst_reg | input | 4 | Destination register number |
| fet_src_mode | input | 2 | Source addressing mode, same encoding |
| fet_src_reg | input | 4 | Source register number |
| wb_addr | input | ADDR_W | Effective data write address of the instruction in writeback |
| stall_req | output | 1 | Insert one NOP into execute this cycle |
| fetch_hold | output | 1 | Hold fetch and decode this cycle |

## Verification
A producer copy that keeps its valid bit through a stall shows up at the ports as a second stall one cycle later, on the held consumer. A producer copy that is never loaded shows up as a missing stall on the very next dependent consumer. A wrong write-set bit is visible in the same cycle the consumer is presented: a stall appears on an unrelated register, or no stall appears on a register written through its mapped address. Checks at the two window edges and on odd byte addresses reveal errors in the address decode without delay.

// File: rtl/raw_hz_pkg.sv
package raw_hz_pkg;

    localparam int NREG      = 16;
    localparam int RIDX_W    = $clog2(NREG);
    localparam int REG_BYTES = 2;
    localparam int REG_SH    = $clog2(REG_BYTES);

    typedef enum logic [1:0] {
        AM_DIR     = 2'b00,
        AM_IND     = 2'b01,
        AM_POSTMOD = 2'b10,
        AM_PREMOD  = 2'b11
    } amode_e;

    typedef logic [RIDX_W-1:0] ridx_t;

    // Destination side of an instruction, kept while it writes back
    typedef struct packed {
        logic   valid;
        amode_e mode;
        ridx_t  rn;
    } dst_t;

    // Source side of the instruction entering operand fetch
    typedef struct packed {
        logic   valid;
        amode_e mode;
        ridx_t  rn;
    } src_t;

    // Source address is formed from a working register
    function automatic logic reads_via_ptr(amode_e m);
        return m != AM_DIR;
    endfunction

    // Pointer register itself is updated by the addressing mode
    function automatic logic updates_ptr(amode_e m);
        return (m == AM_POSTMOD) || (m == AM_PREMOD);
    endfunction

    // Result goes to data memory at an effective address
    function automatic logic stores_mem(amode_e m);
        return m != AM_DIR;
    endfunction

endpackage

// File: rtl/raw_hz_prod_reg.sv
module raw_hz_prod_reg
    import raw_hz_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bubble,
    input  dst_t nxt,
    output dst_t cur
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (bubble) begin
            // consumer held, NOP enters the producer slot
            cur.valid <= 1'b0;
        end else begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/raw_hz_wset.sv
module raw_hz_wset
    import raw_hz_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int MAP_BASE = 0
) (
    input  dst_t              prd,
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   wmask
);

    localparam logic [ADDR_W:0]   WIN_LO = (ADDR_W+1)'(MAP_BASE);
    localparam logic [ADDR_W:0]   WIN_HI = (ADDR_W+1)'(MAP_BASE + NREG * REG_BYTES);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(MAP_BASE);

    logic              map_hit;
    logic [ADDR_W-1:0] offs;
    ridx_t             map_idx;

    always_comb begin
        map_hit = ({1'b0, addr} >= WIN_LO) && ({1'b0, addr} < WIN_HI);
        offs    = addr - BASE_A;
        map_idx = ridx_t'(offs >> REG_SH);
    end

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        logic named_hit;
        logic mapped_hit;
        always_comb begin
            named_hit  = prd.valid
                      && ((prd.mode == AM_DIR) || updates_ptr(prd.mode))
                      && (prd.rn == ridx_t'(k));
            mapped_hit = prd.valid && stores_mem(prd.mode)
                      && map_hit && (map_idx == ridx_t'(k));
            wmask[k]   = named_hit || mapped_hit;
        end
    end

endmodule

// File: rtl/raw_hz_match.sv
module raw_hz_match
    import raw_hz_pkg::*;
(
    input  src_t            cons,
    input  logic [NREG-1:0] wmask,
    output logic            hazard
);

    always_comb begin
        hazard = cons.valid && reads_via_ptr(cons.mode) && wmask[cons.rn];
    end

endmodule

// File: rtl/raw_hz_detect.sv
module raw_hz_detect
    import raw_hz_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int MAP_BASE = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fet_valid,
    input  logic [1:0]        fet_dst_mode,
    input  logic [3:0]        fet_dst_reg,
    input  logic [1:0]        fet_src_mode,
    input  logic [3:0]        fet_src_reg,
    input  logic [ADDR_W-1:0] wb_addr,
    output logic              stall_req,
    output logic              fetch_hold
);

    dst_t            nxt_dst;
    dst_t            prd_dst;
    src_t            cons_src;
    logic [NREG-1:0] wmask;
    logic            hazard;

    always_comb begin
        nxt_dst.valid  = fet_valid;
        nxt_dst.mode   = amode_e'(fet_dst_mode);
        nxt_dst.rn     = ridx_t'(fet_dst_reg);
        cons_src.valid = fet_valid;
        cons_src.mode  = amode_e'(fet_src_mode);
        cons_src.rn    = ridx_t'(fet_src_reg);
    end

    raw_hz_prod_reg u_prod (
        .clk    (clk),
        .rst    (rst),
        .bubble (hazard),
        .nxt    (nxt_dst),
        .cur    (prd_dst)
    );

    raw_hz_wset #(
        .ADDR_W   (ADDR_W),
        .MAP_BASE (MAP_BASE)
    ) u_wset (
        .prd   (prd_dst),
        .addr  (wb_addr),
        .wmask (wmask)
    );

    raw_hz_match u_match (
        .cons   (cons_src),
        .wmask  (wmask),
        .hazard (hazard)
    );

    assign stall_req  = hazard;
    assign fetch_hold = hazard;

endmodule

// File: rtl/raw_hz_detect_chk.sv
module raw_hz_detect_chk (
    input logic       clk,
    input logic       rst,
    input logic       fet_valid,
    input logic [1:0] fet_src_mode,
    input logic       stall_req
);

    AST_FIRST_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !stall_req); // R1

    AST_DIRECT_SRC_FREE: assert property (@(posedge clk) disable iff (rst)
        (fet_src_mode == 2'b00) |-> !stall_req); // R2

    AST_SINGLE_STALL: assert property (@(posedge clk) disable iff (rst)
        stall_req |=> !stall_req); // R8

    AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        !fet_valid |-> !stall_req); // R9

    AST_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
        ($past(!fet_valid) && !$past(rst)) |-> !stall_req); // R9

endmodule

bind raw_hz_detect raw_hz_detect_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .fet_valid    (fet_valid),
    .fet_src_mode (fet_src_mode),
    .stall_req    (stall_req)
);

// File: tb/raw_hz_detect_bench.sv
module raw_hz_detect_bench;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 16;

    localparam logic [1:0] DIR = 2'b00;
    localparam logic [1:0] IND = 2'b01;
    localparam logic [1:0] PST = 2'b10;
    localparam logic [1:0] PRE = 2'b11;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              fet_valid = 1'b0;
    logic [1:0]        fet_dst_mode = 2'b00;
    logic [3:0]        fet_dst_reg = 4'd0;
    logic [1:0]        fet_src_mode = 2'b00;
    logic [3:0]        fet_src_reg = 4'd0;
    logic [ADDR_W-1:0] wb_addr = '0;
    logic              stall_req;
    logic              fetch_hold;

    typedef struct {
        logic  exp;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_cmp  = 0;
    int   n_bad  = 0;
    bit   done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    raw_hz_detect #(.ADDR_W(ADDR_W), .MAP_BASE(0)) u_raw_hz_detect (
        .clk          (clk),
        .rst          (rst),
        .fet_valid    (fet_valid),
        .fet_dst_mode (fet_dst_mode),
        .fet_dst_reg  (fet_dst_reg),
        .fet_src_mode (fet_src_mode),
        .fet_src_reg  (fet_src_reg),
        .wb_addr      (wb_addr),
        .stall_req    (stall_req),
        .fetch_hold   (fetch_hold)
    );

    // Driver: one instruction per cycle, expected stall pushed to scoreboard
    task automatic step(input logic v, input logic [1:0] dm, input logic [3:0] dr,
                        input logic [1:0] sm, input logic [3:0] sr,
                        input logic [ADDR_W-1:0] a, input logic e, input string tag);
        exp_t it;
        @(negedge clk);
        fet_valid    = v;
        fet_dst_mode = dm;
        fet_dst_reg  = dr;
        fet_src_mode = sm;
        fet_src_reg  = sr;
        wb_addr      = a;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst       = 1'b1;
        fet_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Monitor: compares outputs mid-cycle against the scoreboard
    always @(negedge clk) begin
        #(CLK_P/4);
        if (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            n_cmp++;
            if (stall_req !== it.exp) begin
                n_bad++;
                $display("FAIL %s stall_req actual=%b expected=%b", it.tag, stall_req, it.exp);
            end
            n_cmp++;
            if (fetch_hold !== it.exp) begin
                n_bad++;
                $display("FAIL %s fetch_hold actual=%b expected=%b (R8)", it.tag, fetch_hold, it.exp);
            end
        end
    end

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: empty producer slot after reset
        step(1, DIR, 4'd2,  IND, 4'd2,  16'h0000, 1'b0, "R1");
        // R2: direct source never stalls
        step(1, DIR, 4'd3,  DIR, 4'd0,  16'h0000, 1'b0, "R2");
        step(1, DIR, 4'd3,  DIR, 4'd3,  16'h0000, 1'b0, "R2");
        // R3: direct write then pointer read, then R8 held repeat
        step(1, DIR, 4'd5,  IND, 4'd3,  16'h0000, 1'b1, "R3");
        step(1, DIR, 4'd5,  IND, 4'd3,  16'h0000, 1'b0, "R8");
        step(1, DIR, 4'd6,  PST, 4'd5,  16'h0000, 1'b1, "R3");
        step(1, DIR, 4'd6,  PST, 4'd5,  16'h0000, 1'b0, "R8");
        // R4: plain indirect store far from the window
        step(1, IND, 4'd7,  DIR, 4'd0,  16'h0000, 1'b0, "R2");
        step(1, DIR, 4'd1,  IND, 4'd7,  16'h0100, 1'b0, "R4");
        step(1, IND, 4'd8,  PRE, 4'd1,  16'h0000, 1'b1, "R3");
        step(1, IND, 4'd8,  PRE, 4'd1,  16'h0000, 1'b0, "R8");
        // R5: store to address 0x08 lands on W4
        step(1, DIR, 4'd0,  IND, 4'd4,  16'h0008, 1'b1, "R5");
        step(1, DIR, 4'd0,  IND, 4'd4,  16'h0000, 1'b0, "R8");
        step(1, IND, 4'd9,  DIR, 4'd0,  16'h0000, 1'b0, "R2");
        // R5: odd byte 0x05 lands on W2
        step(1, DIR, 4'd0,  PST, 4'd2,  16'h0005, 1'b1, "R5");
        step(1, DIR, 4'd0,  PST, 4'd2,  16'h0000, 1'b0, "R8");
        // R6: modified destination pointer
        step(1, PST, 4'd10, DIR, 4'd0,  16'h0000, 1'b0, "R2");
        step(1, DIR, 4'd11, DIR, 4'd10, 16'h0200, 1'b0, "R6");
        step(1, PRE, 4'd12, DIR, 4'd0,  16'h0000, 1'b0, "R2");
        step(1, DIR, 4'd13, IND, 4'd12, 16'h0300, 1'b1, "R6");
        step(1, DIR, 4'd13, IND, 4'd12, 16'h0000, 1'b0, "R8");
        step(1, PST, 4'd14, DIR, 4'd0,  16'h0000, 1'b0, "R2");
        step(1, DIR, 4'd0,  PRE, 4'd14, 16'h0400, 1'b1, "R6");
        step(1, DIR, 4'd0,  PRE, 4'd14, 16'h0000, 1'b0, "R8");
        // R7: register mismatch
        step(1, DIR, 4'd15, IND, 4'd1,  16'h0000, 1'b0, "R7");
        step(1, IND, 4'd3,  IND, 4'd14, 16'h0000, 1'b0, "R7");
        // R4: first address past the window (0x20)
        step(1, DIR, 4'd0,  IND, 4'd6,  16'h0020, 1'b0, "R4");
        step(1, IND, 4'd3,  IND, 4'd0,  16'h0000, 1'b1, "R3");
        step(1, IND, 4'd3,  IND, 4'd0,  16'h0000, 1'b0, "R8");
        // R5: top byte of the window 0x1E lands on W15
        step(1, DIR, 4'd1,  IND, 4'd15, 16'h001E, 1'b1, "R5");
        step(1, DIR, 4'd1,  IND, 4'd15, 16'h0000, 1'b0, "R8");
        // R9: invalid consumer, then consumer after invalid slot
        step(0, DIR, 4'd0,  IND, 4'd1,  16'h0000, 1'b0, "R9");
        step(1, DIR, 4'd2,  IND, 4'd1,  16'h0000, 1'b0, "R9");
        step(1, DIR, 4'd4,  IND, 4'd2,  16'h0000, 1'b1, "R3");
        step(1, DIR, 4'd4,  IND, 4'd2,  16'h0000, 1'b0, "R8");
        // R1: reset in mid-run empties the producer slot
        step(1, DIR, 4'd5,  DIR, 4'd0,  16'h0000, 1'b0, "R2");
        do_reset();
        step(1, DIR, 4'd0,  IND, 4'd5,  16'h0000, 1'b0, "R1");
        step(0, DIR, 4'd0,  DIR, 4'd0,  16'h0000, 1'b0, "R9");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule